// File: doc/BRIEF.md
# Glitch-Masking Two-Source Clock Switch

This block picks one of two free-running, unrelated source clocks and drives a single system clock from it. A level on the select input names the wanted source: low for source A, high for source B. A change of select is not applied at once. It walks through a short register chain, and that chain is clocked by the currently selected source path. The handover therefore always starts on an edge of the clock that is driving the system at that moment.

When the path-select stage of the chain flips, the mux switches to the new source. The two sources may be close to opposite phase, so the new path could start with a runt pulse. An XOR of the path-select stage and the stage after it opens a mask window. While that window is open, the output is held at logic one. The window closes on the first rising edge of the new source, when the last stage catches up. From then on the new source reaches the output directly. A select change that arrives while a change is still moving through the chain is held back until every stage agrees.

Top module: `clksw_top`

## Requirements
- R1: With select low the output runs at the period of source A, and with select high at the period of source B, once a handover has completed.
- R2: A synchronous, active-high reset clears every chain stage to zero, so source A drives the output even while select is held high.
- R3: A settled chain loads select into its first stage on the next rising output edge. The path changes on the second rising output edge after the select change. The output period between those two edges is still that of the old source.
- R4: From the path change until the next rising edge of the new source, the output stays high. It then falls together with the new source, so the first high phase lasts at least half a period of the new source.
- R5: For source phase offsets of 0, 90 and 180 degrees, no high or low phase of the output is shorter than the shorter half-period of the two sources.
- R6: Within three output cycles after the mask window closes, the output period equals the period of the newly selected source.
- R7: While any two chain stages differ, the first stage holds its value and a new select level is ignored. The pending level is taken only once the chain has settled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset, sampled on rising edges of the selected path |
| clk_a | input | 1 | Source clock A, chosen when select is low |
| clk_b | input | 1 | Source clock B, chosen when select is high |
| sel | input | 1 | Source select level (0 = A, 1 = B) |
| clk_out | output | 1 | System clock output |

## Verification
On every edge of the selected path, the bound checker watches the chain. It checks that reset clears the chain, that a settled chain takes in select, that a pending change holds the first stage, that the mask window lasts a single chain edge, and that only one step of a change is in flight at a time. Properties of the output waveform cannot be seen by edge-sampled properties and are left to the scenarios. These are the width of each phase, the extended high phase at handover, the handover latency measured as periods, and the output frequency after each switch, swept over several phase offsets and a period mismatch.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } clksw_src_e;

  localparam int unsigned CLKSW_MIN_DEPTH = 3;
endpackage

// File: rtl/clksw_chain.sv
module clksw_chain #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  output logic [DEPTH-1:0] stg
);
  // the chain is settled when every stage holds the same level
  logic settled;
  assign settled = (&stg) | ~(|stg);

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
    logic q;
    logic d;
    if (gi == 0) begin : g_head
      // new select level is admitted only into a settled chain
      assign d = settled ? sel : stg[0];
    end else begin : g_body
      assign d = stg[gi-1];
    end
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= d;
    end
    assign stg[gi] = q;
  end
endmodule

// File: rtl/clksw_gate.sv
module clksw_gate
  import clksw_pkg::*;
(
  input  logic clk_a,
  input  logic clk_b,
  input  logic path_sel,
  input  logic lag_sel,
  output logic clk_pre,
  output logic clk_out
);
  // one process so the mux and the mask change in the same evaluation
  always_comb begin
    clksw_src_e src;
    src     = clksw_src_e'(path_sel);
    clk_pre = (src == SRC_B) ? clk_b : clk_a;
    clk_out = clk_pre | (path_sel ^ lag_sel);
  end
endmodule

// File: rtl/clksw_top.sv
module clksw_top #(
  parameter int unsigned DEPTH = 3
) (
  input  logic rst,
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel,
  output logic clk_out
);
  localparam int unsigned PATH_IDX = DEPTH - 2;
  localparam int unsigned LAG_IDX  = DEPTH - 1;

  logic [DEPTH-1:0] stg;
  logic             clk_pre;

  clksw_chain #(.DEPTH(DEPTH)) u_chain (
    .clk (clk_pre),
    .rst (rst),
    .sel (sel),
    .stg (stg)
  );

  clksw_gate u_gate (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .path_sel (stg[PATH_IDX]),
    .lag_sel  (stg[LAG_IDX]),
    .clk_pre  (clk_pre),
    .clk_out  (clk_out)
  );
endmodule

// File: rtl/clksw_chk.sv
module clksw_chk #(
  parameter int unsigned DEPTH = 3
) (
  input logic             clk_pre,
  input logic             rst,
  input logic             sel,
  input logic [DEPTH-1:0] stg
);
  localparam int unsigned PATH_IDX = DEPTH - 2;
  localparam int unsigned LAG_IDX  = DEPTH - 1;

  logic             calm;
  logic [DEPTH-2:0] steps;
  assign calm  = (&stg) | ~(|stg);
  assign steps = stg[DEPTH-1:1] ^ stg[DEPTH-2:0];

  AST_RESET_CLEARS: assert property (@(posedge clk_pre) rst |=> (stg == '0)); // R2
  AST_SEL_TAKEN: assert property (@(posedge clk_pre) disable iff (rst)
    calm |=> (stg[0] == $past(sel))); // R3
  AST_HOLD_PENDING: assert property (@(posedge clk_pre) disable iff (rst)
    !calm |=> $stable(stg[0])); // R7
  AST_MASK_ONE_EDGE: assert property (@(posedge clk_pre) disable iff (rst)
    (stg[PATH_IDX] != stg[LAG_IDX]) |=> (stg[PATH_IDX] == stg[LAG_IDX])); // R4
  AST_SINGLE_STEP: assert property (@(posedge clk_pre) disable iff (rst)
    $countones(steps) <= 1); // R7
endmodule

bind clksw_top clksw_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_pre (clk_pre),
  .rst     (rst),
  .sel     (sel),
  .stg     (stg)
);

// File: tb/sim_clksw_top.sv
`timescale 1ns/1ps
module sim_clksw_top;
  localparam real CLK_PERIOD = 10.0;
  localparam real STEP       = 0.5;

  logic rst = 1'b1;
  logic sel = 1'b0;
  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic clk_out;

  real per_a = CLK_PERIOD;
  real per_b = CLK_PERIOD;
  real off_b = 0.0;
  real tnow  = 0.0;
  real last_edge = 0.0;
  int  errors = 0;
  int  checks = 0;
  bit  mon_en = 1'b0;

  clksw_top #(.DEPTH(3)) u0 (
    .rst     (rst),
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .sel     (sel),
    .clk_out (clk_out)
  );

  function automatic logic wave(real t, real p, real o);
    real r;
    r = t - o;
    r = r - p * $floor(r / p);
    return r < p / 2.0;
  endfunction

  initial begin
    forever begin
      #(STEP);
      tnow += STEP;
      clk_a = wave(tnow, per_a, 0.0);
      clk_b = wave(tnow, per_b, off_b);
    end
  end

  function automatic bit near(real x, real y);
    return (x - y < 0.01) && (y - x < 0.01);
  endfunction

  task automatic check(bit ok, string req, real act, real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0.3f expected=%0.3f at %0t", req, act, exp, $realtime);
    end
  endtask

  // R5: every phase of the output at least the shorter source half-period
  always @(clk_out) begin
    real w;
    real lim;
    w   = $realtime - last_edge;
    lim = (per_a < per_b) ? per_a / 2.0 : per_b / 2.0;
    if (mon_en) check(w >= lim - 0.001, "R5 phase width", w, lim);
    last_edge = $realtime;
  end

  task automatic wait_rise(output real t);
    @(posedge clk_out);
    t = $realtime;
  endtask

  task automatic measure_period(output real p);
    real t0;
    real t1;
    wait_rise(t0);
    wait_rise(t1);
    p = t1 - t0;
  endtask

  task automatic test_reset_start;
    real p;
    real t;
    repeat (4) wait_rise(t);
    #0.25 rst = 1'b0;
    measure_period(p);
    check(near(p, per_a), "R2 reset selects A", p, per_a);
    mon_en = 1'b1;
  endtask

  // R1 R3 R4 R6: one switch with old-period latency, mask and new frequency
  task automatic do_switch(bit v);
    real t0, t1, t2, t3, p, oldp, newp;
    oldp = v ? per_a : per_b;
    newp = v ? per_b : per_a;
    wait_rise(t0);
    #0.25 sel = v;
    wait_rise(t1);
    wait_rise(t2);
    check(near(t2 - t1, oldp), "R3 old period before handover", t2 - t1, oldp);
    @(negedge clk_out);
    t3 = $realtime;
    check(t3 - t2 >= newp / 2.0 - 0.001, "R4 extended high phase", t3 - t2, newp / 2.0);
    #0.1;
    check((v ? clk_b : clk_a) == 1'b0, "R4 falls with new source", clk_out, 0.0);
    measure_period(p);
    check(near(p, newp), "R6 R1 new source period", p, newp);
  endtask

  task automatic test_reset_hold;
    real t;
    real p;
    mon_en = 1'b0;
    wait_rise(t);
    #0.25 rst = 1'b1;
    repeat (3) wait_rise(t);
    measure_period(p);
    check(near(p, per_a), "R2 reset forces A with sel high", p, per_a);
    #0.25 rst = 1'b0;
    repeat (4) wait_rise(t);
    measure_period(p);
    check(near(p, per_b), "R1 B after reset release", p, per_b);
    mon_en = 1'b1;
  endtask

  task automatic test_hold_off;
    real t, ta, tb, p;
    wait_rise(t);
    #0.25 sel = 1'b1;
    wait_rise(t);
    wait_rise(t);
    #0.25 sel = 1'b0;
    @(negedge clk_out);
    wait_rise(ta);
    wait_rise(tb);
    check(near(tb - ta, per_b), "R7 late change waits for settle", tb - ta, per_b);
    @(negedge clk_out);
    measure_period(p);
    check(near(p, per_a), "R7 pending level applied", p, per_a);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000.0);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    test_reset_start();
    foreach (off_arr[i]) begin
    end
    // phase offsets 0, 90 and 180 degrees with equal periods (R5)
    for (int k = 0; k < 3; k++) begin
      off_b = CLK_PERIOD * k / 4.0;
      do_switch(1'b1);
      do_switch(1'b0);
    end
    per_b = 14.0;
    off_b = 1.5;
    do_switch(1'b1);
    test_reset_hold();
    do_switch(1'b0);
    test_hold_off();
    finish_run();
  end

  real off_arr [1];
endmodule